// File: doc/BRIEF.md
# Supervisor Timer Compare Unit

This block gives supervisor software its own timer interrupt source. It holds a 64-bit compare value that is reached through CSR accesses and compares it each cycle against a free-running 64-bit machine time input. When time has reached the compare value, it raises a timer-pending level. That level is the only source of the supervisor timer bit in both the machine and the supervisor interrupt-pending views. Software cannot write that bit. It clears the level by programming a compare value larger than the current time.

The CSR port is a simple decoded access. Each cycle it takes an address, a read strobe, a write strobe with write data, and the privilege mode of the access. Read data and an illegal-instruction flag are returned combinationally in the same cycle. A write that is legal takes effect at the next clock edge. On a 32-bit hart the compare value is split across two CSR numbers, one for the lower word and one for the upper word. On a 64-bit hart a single CSR number holds the whole value. Supervisor access to the compare value is gated by the machine counter-enable TM bit.

Top module: `sup_tmr_top`

## Requirements
- R1: After reset the compare value is all ones, and the pending output is low while time is below all ones.
- R2: With XLEN=32, CSR 0x108 reads and writes compare bits 31:0 and CSR 0x109 reads and writes bits 63:32. A write to one half leaves the other half unchanged.
- R3: With XLEN=64, CSR 0x108 reads and writes all 64 bits. Any access to 0x109 raises the illegal flag and changes nothing.
- R4: The pending output equals (time >= compare) taken as an unsigned compare of the time and compare value present before the previous clock edge. It therefore lags a time change or a committed write by exactly one clock.
- R5: The pending output is a level. It stays high for as long as time stays at or above the compare value, and it falls only after a larger compare value has been written.
- R6: CSR 0x344 (machine view) and CSR 0x144 (supervisor view) read the pending output at bit 5 with all other bits zero. Writes to these CSRs change no state.
- R7: A supervisor-mode access (priv 2'b01) to a compare CSR with TM clear raises the illegal flag, and the write is dropped. With TM set the access is performed. Supervisor mode may read 0x144 but not 0x344.
- R8: Machine-mode accesses (priv 2'b11) to the block's CSRs are always legal. User mode (2'b00) and the reserved mode (2'b10) raise the illegal flag on every block CSR and change nothing.
- R9: An address outside the block's CSR set returns read data zero, never raises the illegal flag and changes no state. An illegal access also returns read data zero.
- R10: The illegal flag is raised only in a cycle where the read or write strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| csr_addr_i | input | 12 | CSR number of the access |
| csr_rd_i | input | 1 | Read strobe |
| csr_we_i | input | 1 | Write strobe |
| csr_wdata_i | input | XLEN | Write data |
| priv_i | input | 2 | Privilege mode of the access (00 U, 01 S, 11 M) |
| tm_en_i | input | 1 | Machine counter-enable TM bit |
| mtime_i | input | 64 | Machine time value |
| csr_rdata_o | output | XLEN | Read data, zero when illegal or not decoded |
| csr_illegal_o | output | 1 | Illegal-instruction flag for the current access |
| timer_pend_o | output | 1 | Supervisor timer pending level |

## Verification
The bench runs a 32-bit instance and a 64-bit instance side by side. Every privilege mode, TM value and address, including an undecoded address, is tried with reads, writes and idle strobes. This sweep separates the gating rules from one another and from the address decode. After each write in the sweep a machine-mode readback shows whether the write was committed or dropped. The compare is then tried at one below, equal to and one above several time values. These values sit at the word boundary, at the sign bit and near the top of the range, which distinguishes an unsigned greater-or-equal from a signed compare or a strict compare. Separate cycle-timed steps check the one-clock lag, that the level holds, and that writing one half leaves the other half unchanged.

// File: rtl/sup_tmr_pkg.sv
package sup_tmr_pkg;
  typedef enum logic [1:0] {
    PRIV_U   = 2'b00,
    PRIV_S   = 2'b01,
    PRIV_RSV = 2'b10,
    PRIV_M   = 2'b11
  } priv_e;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_LO   = 2'd1,
    SEL_HI   = 2'd2,
    SEL_VIEW = 2'd3
  } sel_e;

  localparam int unsigned CMP_W     = 64;
  localparam int unsigned ADDR_W    = 12;
  localparam int unsigned PEND_BIT  = 5;
  localparam logic [ADDR_W-1:0] A_CMP_LO = 12'h108;
  localparam logic [ADDR_W-1:0] A_CMP_HI = 12'h109;
  localparam logic [ADDR_W-1:0] A_SVIEW  = 12'h144;
  localparam logic [ADDR_W-1:0] A_MVIEW  = 12'h344;
endpackage

// File: rtl/sup_tmr_dec.sv
module sup_tmr_dec
  import sup_tmr_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        priv_i,
  input  logic              tm_en_i,
  input  logic              access_i,
  output sel_e              sel_o,
  output logic              illegal_o
);
  localparam bit IS_W32 = (XLEN == 32);

  logic known, absent, is_cmp, need_m, allowed;

  always_comb begin
    sel_o  = SEL_NONE;
    known  = 1'b0;
    absent = 1'b0;
    is_cmp = 1'b0;
    need_m = 1'b0;
    unique case (addr_i)
      A_CMP_LO: begin sel_o = SEL_LO; known = 1'b1; is_cmp = 1'b1; end
      A_CMP_HI: begin
        known  = 1'b1;
        is_cmp = 1'b1;
        if (IS_W32) sel_o = SEL_HI;
        else        absent = 1'b1;
      end
      A_SVIEW:  begin sel_o = SEL_VIEW; known = 1'b1; end
      A_MVIEW:  begin sel_o = SEL_VIEW; known = 1'b1; need_m = 1'b1; end
      default:  ;
    endcase
  end

  always_comb begin
    unique case (priv_e'(priv_i))
      PRIV_M:  allowed = 1'b1;
      PRIV_S:  allowed = !need_m && (!is_cmp || tm_en_i);
      default: allowed = 1'b0;
    endcase
  end

  assign illegal_o = access_i && known && (absent || !allowed);
endmodule

// File: rtl/sup_tmr_cmp_reg.sv
module sup_tmr_cmp_reg
  import sup_tmr_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_lo_i,
  input  logic             we_hi_i,
  input  logic [XLEN-1:0]  wdata_i,
  output logic [CMP_W-1:0] cmp_o
);
  localparam int unsigned HALF_W = CMP_W / 2;

  generate
    if (XLEN == 32) begin : g_split
      logic [HALF_W-1:0] lo_q, hi_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          lo_q <= '1;
          hi_q <= '1;
        end else begin
          if (we_lo_i) lo_q <= HALF_W'(wdata_i);
          if (we_hi_i) hi_q <= HALF_W'(wdata_i);
        end
      end
      assign cmp_o = {hi_q, lo_q};
    end else begin : g_full
      logic [CMP_W-1:0] full_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                full_q <= '1;
        else if (we_lo_i || we_hi_i) full_q <= CMP_W'(wdata_i);
      end
      assign cmp_o = full_q;
    end
  endgenerate
endmodule

// File: rtl/sup_tmr_pend.sv
module sup_tmr_pend
  import sup_tmr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CMP_W-1:0] cmp_i,
  input  logic [CMP_W-1:0] mtime_i,
  output logic             pend_o
);
  logic reached;
  assign reached = (mtime_i >= cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_o <= 1'b0;
    else         pend_o <= reached;
  end
endmodule

// File: rtl/sup_tmr_top.sv
module sup_tmr_top
  import sup_tmr_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] csr_addr_i,
  input  logic              csr_rd_i,
  input  logic              csr_we_i,
  input  logic [XLEN-1:0]   csr_wdata_i,
  input  logic [1:0]        priv_i,
  input  logic              tm_en_i,
  input  logic [CMP_W-1:0]  mtime_i,
  output logic [XLEN-1:0]   csr_rdata_o,
  output logic              csr_illegal_o,
  output logic              timer_pend_o
);
  localparam int unsigned HALF_W = CMP_W / 2;

  sel_e             sel;
  logic             illegal;
  logic             wr_ok;
  logic [CMP_W-1:0] cmp_q;

  sup_tmr_dec #(.XLEN(XLEN)) u_dec (
    .addr_i   (csr_addr_i),
    .priv_i   (priv_i),
    .tm_en_i  (tm_en_i),
    .access_i (csr_rd_i || csr_we_i),
    .sel_o    (sel),
    .illegal_o(illegal)
  );

  assign wr_ok = csr_we_i && !illegal;

  sup_tmr_cmp_reg #(.XLEN(XLEN)) u_cmp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_lo_i(wr_ok && (sel == SEL_LO)),
    .we_hi_i(wr_ok && (sel == SEL_HI)),
    .wdata_i(csr_wdata_i),
    .cmp_o  (cmp_q)
  );

  sup_tmr_pend u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cmp_i  (cmp_q),
    .mtime_i(mtime_i),
    .pend_o (timer_pend_o)
  );

  always_comb begin
    csr_rdata_o = '0;
    if (!illegal) begin
      unique case (sel)
        SEL_LO:   csr_rdata_o = XLEN'(cmp_q);
        SEL_HI:   csr_rdata_o = XLEN'(cmp_q >> HALF_W);
        SEL_VIEW: csr_rdata_o = XLEN'(timer_pend_o) << PEND_BIT;
        default:  csr_rdata_o = '0;
      endcase
    end
  end

  assign csr_illegal_o = illegal;
endmodule

// File: rtl/sup_tmr_chk.sv
module sup_tmr_chk
  import sup_tmr_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] csr_addr_i,
  input logic              csr_rd_i,
  input logic              csr_we_i,
  input logic [1:0]        priv_i,
  input logic              tm_en_i,
  input logic [CMP_W-1:0]  mtime_i,
  input logic [XLEN-1:0]   csr_rdata_o,
  input logic              csr_illegal_o,
  input logic              timer_pend_o,
  input logic [CMP_W-1:0]  cmp_q
);
  logic past_ok;
  logic acc;
  logic is_view;

  assign acc     = csr_rd_i || csr_we_i;
  assign is_view = (csr_addr_i == A_SVIEW) || (csr_addr_i == A_MVIEW);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  AST_PEND_TRACKS_CMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (timer_pend_o == ($past(mtime_i) >= $past(cmp_q)))); // R4

  AST_PEND_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && timer_pend_o && $stable(cmp_q) && (mtime_i >= cmp_q)) |=> timer_pend_o); // R5

  AST_USER_ILLEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && (priv_i == PRIV_U) && (csr_addr_i == A_CMP_LO)) |-> csr_illegal_o); // R8

  AST_MACHINE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && (priv_i == PRIV_M) && (csr_addr_i == A_CMP_LO)) |-> !csr_illegal_o); // R8

  AST_S_TM_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && (priv_i == PRIV_S) && !tm_en_i && (csr_addr_i == A_CMP_LO)) |-> csr_illegal_o); // R7

  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && csr_illegal_o) |=> $stable(cmp_q)); // R7

  AST_VIEW_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && is_view) |=> $stable(cmp_q)); // R6

  AST_VIEW_READ_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_rd_i && !csr_illegal_o && is_view) |-> (csr_rdata_o[PEND_BIT] == timer_pend_o)); // R6

  AST_NO_STROBE_NO_ILLEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |-> !csr_illegal_o); // R10

  AST_ILLEGAL_ZERO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_illegal_o |-> (csr_rdata_o == '0)); // R9
endmodule

bind sup_tmr_top sup_tmr_chk #(.XLEN(XLEN)) u_sup_tmr_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .csr_addr_i   (csr_addr_i),
  .csr_rd_i     (csr_rd_i),
  .csr_we_i     (csr_we_i),
  .priv_i       (priv_i),
  .tm_en_i      (tm_en_i),
  .mtime_i      (mtime_i),
  .csr_rdata_o  (csr_rdata_o),
  .csr_illegal_o(csr_illegal_o),
  .timer_pend_o (timer_pend_o),
  .cmp_q        (cmp_q)
);

// File: tb/sup_tmr_top_bench.sv
module sup_tmr_top_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic [11:0] addr;
  logic        rd, we, tm;
  logic [1:0]  priv;
  logic [63:0] wdata, mtime;
  logic [31:0] r32;
  logic [63:0] r64;
  logic        ill32, ill64, pend32, pend64;

  sup_tmr_top #(.XLEN(32)) u_sup_tmr_top (
    .clk_i(clk), .rst_ni(rst_n), .csr_addr_i(addr), .csr_rd_i(rd), .csr_we_i(we),
    .csr_wdata_i(wdata[31:0]), .priv_i(priv), .tm_en_i(tm), .mtime_i(mtime),
    .csr_rdata_o(r32), .csr_illegal_o(ill32), .timer_pend_o(pend32));

  sup_tmr_top #(.XLEN(64)) u_sup_tmr_top_w64 (
    .clk_i(clk), .rst_ni(rst_n), .csr_addr_i(addr), .csr_rd_i(rd), .csr_we_i(we),
    .csr_wdata_i(wdata), .priv_i(priv), .tm_en_i(tm), .mtime_i(mtime),
    .csr_rdata_o(r64), .csr_illegal_o(ill64), .timer_pend_o(pend64));

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [63:0] m32, m64;
  logic [31:0] s_r32;
  logic [63:0] s_r64;
  logic        s_ill32, s_ill64;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic e_ill(logic [1:0] p, logic t, logic [11:0] a, bit w64);
    logic known, absent, is_cmp, need_m, allowed;
    known   = (a == 12'h108) || (a == 12'h109) || (a == 12'h144) || (a == 12'h344);
    absent  = w64 && (a == 12'h109);
    is_cmp  = (a == 12'h108) || (a == 12'h109);
    need_m  = (a == 12'h344);
    allowed = (p == 2'b11) || ((p == 2'b01) && !need_m && (!is_cmp || t));
    return known && (absent || !allowed);
  endfunction

  function automatic logic [63:0] e_rd(logic [11:0] a, logic ill, logic pnd,
                                       logic [63:0] c, bit w64);
    if (ill) return 64'h0;
    case (a)
      12'h108: return w64 ? c : {32'h0, c[31:0]};
      12'h109: return w64 ? 64'h0 : {32'h0, c[63:32]};
      12'h144, 12'h344: return {63'h0, pnd} << 5;
      default: return 64'h0;
    endcase
  endfunction

  // drive at negedge, sample combinational outputs, write commits at the next posedge
  task automatic access(logic [11:0] a, logic [1:0] p, logic t, logic r, logic w,
                        logic [63:0] d);
    logic e32, e64;
    @(negedge clk);
    addr = a; priv = p; tm = t; rd = r; we = w; wdata = d;
    #2;
    s_r32 = r32; s_r64 = r64; s_ill32 = ill32; s_ill64 = ill64;
    e32 = (r || w) && e_ill(p, t, a, 1'b0);
    e64 = (r || w) && e_ill(p, t, a, 1'b1);
    @(negedge clk);
    rd = 1'b0; we = 1'b0;
    if (w && !e32) begin
      if (a == 12'h108) m32[31:0]  = d[31:0];
      if (a == 12'h109) m32[63:32] = d[31:0];
    end
    if (w && !e64 && (a == 12'h108)) m64 = d;
  endtask

  task automatic set_cmp(logic [63:0] v);
    access(12'h108, 2'b11, 1'b0, 1'b0, 1'b1, v);
    access(12'h109, 2'b11, 1'b0, 1'b0, 1'b1, {32'h0, v[63:32]});
  endtask

  task automatic readback(string req);
    access(12'h108, 2'b11, 1'b0, 1'b1, 1'b0, 64'h0);
    chk({req, " lo32"}, {32'h0, s_r32}, {32'h0, m32[31:0]});
    chk({req, " full64"}, s_r64, m64);
    access(12'h109, 2'b11, 1'b0, 1'b1, 1'b0, 64'h0);
    chk({req, " hi32"}, {32'h0, s_r32}, {32'h0, m32[63:32]});
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [11:0] alist [5];
    logic [63:0] tv [6];
    alist = '{12'h108, 12'h109, 12'h144, 12'h344, 12'h7c0};
    tv = '{64'h0, 64'h1, 64'h0000_0000_ffff_ffff, 64'h0000_0001_0000_0000,
           64'h8000_0000_0000_0000, 64'hffff_ffff_ffff_fffe};
    rst_n = 1'b0; addr = '0; rd = 0; we = 0; tm = 0; priv = 2'b11;
    wdata = '0; mtime = 64'h50;
    m32 = '1; m64 = '1;
    repeat (3) @(negedge clk);
    chk("R1 reset pend32", {63'h0, pend32}, 64'h0);
    chk("R1 reset pend64", {63'h0, pend64}, 64'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 pend32 after reset", {63'h0, pend32}, 64'h0);
    chk("R1 pend64 after reset", {63'h0, pend64}, 64'h0);
    readback("R1 reset value");

    // legality sweep: every mode, TM value, address; idle, read and write
    for (int p = 0; p < 4; p++) begin
      for (int t = 0; t < 2; t++) begin
        for (int i = 0; i < 5; i++) begin
          logic e32, e64;
          e32 = e_ill(2'(p), 1'(t), alist[i], 1'b0);
          e64 = e_ill(2'(p), 1'(t), alist[i], 1'b1);
          access(alist[i], 2'(p), 1'(t), 1'b0, 1'b0, 64'h0);
          chk("R10 no strobe 32", {63'h0, s_ill32}, 64'h0);
          chk("R10 no strobe 64", {63'h0, s_ill64}, 64'h0);
          access(alist[i], 2'(p), 1'(t), 1'b1, 1'b0, 64'h0);
          chk("R7 R8 R9 illegal read 32", {63'h0, s_ill32}, {63'h0, e32});
          chk("R3 R7 R8 R9 illegal read 64", {63'h0, s_ill64}, {63'h0, e64});
          chk("R2 R6 R9 rdata 32", {32'h0, s_r32},
              e_rd(alist[i], e32, (mtime >= m32), m32, 1'b0));
          chk("R3 R6 R9 rdata 64", s_r64,
              e_rd(alist[i], e64, (mtime >= m64), m64, 1'b1));
          access(alist[i], 2'(p), 1'(t), 1'b0, 1'b1,
                 64'hc3a5_0000_0000_0000 | (64'(p) << 40) | (64'(t) << 36) |
                 (64'(i) << 32) | (64'(p * 16 + t * 8 + i) << 8) | 64'hff);
          chk("R7 R8 illegal write 32", {63'h0, s_ill32}, {63'h0, e32});
          chk("R3 illegal write 64", {63'h0, s_ill64}, {63'h0, e64});
          readback("R2 R3 R6 R7 R8 R9 state after write");
        end
      end
    end

    // compare boundaries, unsigned
    foreach (tv[k]) begin
      for (int d = -1; d <= 1; d++) begin
        logic [63:0] cv;
        if (!((tv[k] == 64'h0) && (d < 0))) begin
          cv = tv[k] + 64'(d);
          mtime = tv[k];
          set_cmp(cv);
          repeat (2) @(negedge clk);
          chk("R4 pend32 compare", {63'h0, pend32}, {63'h0, (tv[k] >= cv)});
          chk("R4 pend64 compare", {63'h0, pend64}, {63'h0, (tv[k] >= cv)});
          access(12'h344, 2'b11, 1'b0, 1'b1, 1'b0, 64'h0);
          chk("R6 machine view", {32'h0, s_r32}, {58'h0, (tv[k] >= cv), 5'h0});
          access(12'h144, 2'b01, 1'b0, 1'b1, 1'b0, 64'h0);
          chk("R6 supervisor view", s_r64, {58'h0, (tv[k] >= cv), 5'h0});
        end
      end
    end

    // unsigned: sign bit set in time, small compare
    mtime = 64'h8000_0000_0000_0000;
    set_cmp(64'h1);
    repeat (2) @(negedge clk);
    chk("R4 unsigned 32", {63'h0, pend32}, 64'h1);
    chk("R4 unsigned 64", {63'h0, pend64}, 64'h1);

    // one-clock lag and level hold
    mtime = 64'd99;
    set_cmp(64'd100);
    repeat (2) @(negedge clk);
    chk("R4 below", {63'h0, pend32}, 64'h0);
    mtime = 64'd100;
    #2;
    chk("R4 no change before edge", {63'h0, pend32}, 64'h0);
    @(negedge clk);
    chk("R4 one clock later 32", {63'h0, pend32}, 64'h1);
    chk("R4 one clock later 64", {63'h0, pend64}, 64'h1);
    mtime = 64'd200;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      chk("R5 level holds", {63'h0, pend32 & pend64}, 64'h1);
    end
    access(12'h344, 2'b11, 1'b0, 1'b0, 1'b1, 64'h0);
    access(12'h144, 2'b01, 1'b1, 1'b0, 1'b1, 64'h0);
    @(negedge clk);
    chk("R6 view write ignored", {63'h0, pend32 & pend64}, 64'h1);
    set_cmp(64'd300);
    repeat (2) @(negedge clk);
    chk("R5 cleared by larger compare 32", {63'h0, pend32}, 64'h0);
    chk("R5 cleared by larger compare 64", {63'h0, pend64}, 64'h0);

    // half write independence
    set_cmp(64'h1234_5678_9abc_def0);
    access(12'h109, 2'b01, 1'b1, 1'b0, 1'b1, 64'h0000_0000_0bad_f00d);
    readback("R2 upper-half write keeps lower");
    chk("R2 upper model", m32, 64'h0bad_f00d_9abc_def0);
    access(12'h108, 2'b01, 1'b1, 1'b0, 1'b1, 64'h0000_0000_5555_aaaa);
    readback("R2 lower-half write keeps upper");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule